// File: doc/BRIEF.md
# Stereo Sample Delay Line

This block delays a stereo stream of 24-bit sample pairs by a selectable whole number of sample periods. A serial receiver upstream presents one left/right pair together with a one-cycle valid strobe per frame. The block stores each pair in a circular buffer and returns it exactly the selected number of frames later. Words are never scaled or rounded, so any 24-bit payload, audio or not, comes out identical to the way it went in.

A 6-bit selector sets the delay. Its lowest bit carries the heaviest weight, and a fixed offset is always added, so the span runs from 65 to 4097 frames. The block forces its output to zero while the buffer holds stale or meaningless contents: after reset, and after any change of the selector. The silent span always equals the delay that is selected. A bypass input sends the current input pair straight to the output. The buffer and the mute tracking keep running underneath it.

Top module: `stereo_delay_line`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0 and both output words are 0.
- R2: The delay D in frames is 2048·sel[0] + 1024·sel[1] + 512·sel[2] + 256·sel[3] + 128·sel[4] + 64·sel[5] + 65, where bit 0 of `dly_sel` has the largest weight. When not muted and not bypassed, the pair presented on strobe k is the input pair of strobe k−D.
- R3: The extreme settings give exactly 65 frames (`dly_sel` = 0) and 4097 frames (`dly_sel` = 6'h3F).
- R4: After reset is released, the outputs of the first D strobes are zero.
- R5: On a strobe where `dly_sel` differs from its value at the previous strobe, that strobe and the following D−1 strobes output zero, with D taken from the new setting.
- R6: If the setting changes again while a mute is still running, the mute restarts with the newest delay, and delayed data then appears after that newest D.
- R7: Arbitrary 24-bit words, including all-ones, all-zeros, sign-bit-only and alternating patterns, come out bit-identical, with left and right never exchanged.
- R8: With `bypass` at 1, the pair presented on a strobe is the input pair of that same strobe, even during a mute. Buffer writes and the mute countdown continue during bypass.
- R9: `out_valid` is 1 on exactly the cycle after each strobe. Between strobes the output words hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe per frame; the input pair is sampled on it |
| in_left | input | 24 | Left input word |
| in_right | input | 24 | Right input word |
| dly_sel | input | 6 | Delay selector; bit 0 has the largest weight |
| bypass | input | 1 | 1 = pass the current input pair straight to the output |
| out_valid | output | 1 | High the cycle after a strobe |
| out_left | output | 24 | Left output word |
| out_right | output | 24 | Right output word |

## Verification
The mute reload and the running mute countdown can fall on the same strobe. This happens when the selector changes while a previous mute still has frames left. The bench provokes it by switching to a 193-frame setting 500 frames into a 1089-frame mute. It then expects zeros for exactly 193 strobes counted from that second change, and after that the input from 193 frames earlier. The bench also asserts bypass on the strobe that starts a mute, and expects the live input to win while the countdown below it keeps running.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  // Source of the output register on a frame strobe
  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_SILENT = 2'd1,
    SRC_DIRECT = 2'd2,
    SRC_BUFFER = 2'd3
  } out_src_e;
endpackage

// File: rtl/sdl_lag_decode.sv
// Turns the selector into the buffer lag (delay minus one frame).
// Bit-reversed selector, plus one unit, scaled by 2^UNIT_SHIFT.
module sdl_lag_decode #(
  parameter int SEL_W      = 6,
  parameter int UNIT_SHIFT = 6,
  localparam int LAG_W     = SEL_W + UNIT_SHIFT + 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LAG_W-1:0] lag
);
  logic [SEL_W-1:0] rev;
  logic [SEL_W:0]   steps;

  for (genvar i = 0; i < SEL_W; i++) begin : g_rev
    assign rev[i] = sel[SEL_W-1-i];
  end

  assign steps = {1'b0, rev} + {{SEL_W{1'b0}}, 1'b1};
  assign lag   = {steps, {UNIT_SHIFT{1'b0}}};
endmodule

// File: rtl/sdl_ring_ram.sv
// Circular buffer storage: one write and one read-first registered read
// per strobe, written so that block RAM can be inferred.
module sdl_ring_ram #(
  parameter int AW = 12,
  parameter int W  = 48,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata       <= mem[raddr];
      mem[waddr]  <= wdata;
    end
  end
endmodule

// File: rtl/sdl_mute_ctrl.sv
// Tracks the selector across strobes and keeps the output silent for the
// selected span after reset or after any change of setting.
module sdl_mute_ctrl #(
  parameter int SEL_W = 6,
  parameter int LAG_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [SEL_W-1:0] sel,
  input  logic [LAG_W-1:0] lag,
  output logic             mute_now
);
  logic             init_pend;
  logic [SEL_W-1:0] sel_q;
  logic [LAG_W-1:0] remain;
  logic             reload;

  always_comb begin
    reload   = init_pend || (sel != sel_q);
    mute_now = reload || (remain != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_pend <= 1'b1;
      sel_q     <= '0;
      remain    <= '0;
    end else if (strobe) begin
      init_pend <= 1'b0;
      sel_q     <= sel;
      if (reload)
        remain <= lag;                       // D-1 further silent frames
      else if (remain != '0)
        remain <= remain - LAG_W'(1);
    end
  end
endmodule

// File: rtl/stereo_delay_line.sv
module stereo_delay_line #(
  parameter int DATA_W     = 24,
  parameter int SEL_W      = 6,
  parameter int UNIT_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic [SEL_W-1:0]  dly_sel,
  input  logic              bypass,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  import sdl_pkg::*;

  localparam int AW     = SEL_W + UNIT_SHIFT;
  localparam int LAG_W  = AW + 1;
  localparam int WORD_W = 2 * DATA_W;

  logic [LAG_W-1:0]  lag;
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic              mute_now;
  out_src_e          src;

  sdl_lag_decode #(.SEL_W(SEL_W), .UNIT_SHIFT(UNIT_SHIFT)) u_decode (
    .sel (dly_sel),
    .lag (lag)
  );

  sdl_mute_ctrl #(.SEL_W(SEL_W), .LAG_W(LAG_W)) u_mute (
    .clk      (clk),
    .rst      (rst),
    .strobe   (smp_valid),
    .sel      (dly_sel),
    .lag      (lag),
    .mute_now (mute_now)
  );

  // The read trails the write by D-1. The output register adds the last frame.
  assign rd_addr = wr_ptr - lag[AW-1:0];

  sdl_ring_ram #(.AW(AW), .W(WORD_W)) u_ram (
    .clk   (clk),
    .en    (smp_valid),
    .waddr (wr_ptr),
    .wdata ({in_left, in_right}),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_ptr <= '0;
    else if (smp_valid) wr_ptr <= wr_ptr + AW'(1);
  end

  always_comb begin
    if (!smp_valid)    src = SRC_HOLD;
    else if (bypass)   src = SRC_DIRECT;
    else if (mute_now) src = SRC_SILENT;
    else               src = SRC_BUFFER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= smp_valid;
      case (src)
        SRC_DIRECT: begin
          out_left  <= in_left;
          out_right <= in_right;
        end
        SRC_SILENT: begin
          out_left  <= '0;
          out_right <= '0;
        end
        SRC_BUFFER: begin
          out_left  <= rd_word[WORD_W-1:DATA_W];
          out_right <= rd_word[DATA_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker #(
  parameter int DATA_W = 24,
  parameter int SEL_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic [DATA_W-1:0] in_left,
  input logic [DATA_W-1:0] in_right,
  input logic [SEL_W-1:0]  dly_sel,
  input logic              bypass,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right
);
  logic             seen;
  logic [SEL_W-1:0] prev_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      prev_sel <= '0;
    end else if (smp_valid) begin
      seen     <= 1'b1;
      prev_sel <= dly_sel;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> out_valid);

  assert_valid_only_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(out_left) && $stable(out_right)));

  assert_bypass_live_R8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && bypass) |=>
      (out_left == $past(in_left) && out_right == $past(in_right)));

  assert_first_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !bypass && !seen) |=> (out_left == '0 && out_right == '0));

  assert_change_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !bypass && seen && dly_sel != prev_sel) |=>
      (out_left == '0 && out_right == '0));
endmodule

bind stereo_delay_line sdl_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .in_left   (in_left),
  .in_right  (in_right),
  .dly_sel   (dly_sel),
  .bypass    (bypass),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right)
);

// File: tb/stereo_delay_line_bench.sv
module stereo_delay_line_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [5:0]  dly_sel = '0;
  logic        bypass = 1'b0;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  stereo_delay_line u_stereo_delay_line (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .in_left(in_left), .in_right(in_right),
    .dly_sel(dly_sel), .bypass(bypass),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  // scoreboard
  logic [23:0] q_l[$], q_r[$];
  string       q_tag[$];

  // reference model state
  logic [47:0] hist [int];
  int          k_idx;
  bit          first;
  logic [5:0]  prev_sel;
  int          mcnt;
  string       mreason;
  bit          na_phase = 0;

  task automatic check(input bit ok, input string tag, input logic [47:0] act,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int delay_of(input logic [5:0] s);
    int d = 65;
    for (int i = 0; i < 6; i++) if (s[i]) d += (2048 >> i);
    return d;
  endfunction

  task automatic model_reset();
    hist.delete();
    k_idx = 0; first = 1; prev_sel = '0; mcnt = 0; mreason = "R4";
  endtask

  task automatic send(input logic [23:0] l, input logic [23:0] r);
    int d;
    bit muted;
    logic [23:0] el, er;
    string tag;
    d = delay_of(dly_sel);
    if (first) begin
      mcnt = d - 1; mreason = "R4"; muted = 1;
    end else if (dly_sel != prev_sel) begin
      mreason = (mcnt > 0) ? "R6" : "R5";
      mcnt = d - 1; muted = 1;
    end else if (mcnt > 0) begin
      mcnt--; muted = 1;
    end else muted = 0;
    if (bypass) begin
      el = l; er = r; tag = "R8";
    end else if (muted) begin
      el = '0; er = '0; tag = mreason;
    end else begin
      {el, er} = hist[k_idx - d];
      tag = na_phase ? "R7" : ((dly_sel == 6'h00 || dly_sel == 6'h3F) ? "R3" : "R2");
    end
    hist[k_idx] = {l, r};
    k_idx++; first = 0; prev_sel = dly_sel;
    q_l.push_back(el); q_r.push_back(er); q_tag.push_back(tag);
    @(negedge clk);
    in_left = l; in_right = r; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  logic [23:0] last_l = '0, last_r = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        last_l = '0; last_r = '0;
      end else if (out_valid) begin
        if (q_l.size() == 0) begin
          check(0, "R9 unexpected out_valid", {23'd0, out_valid}, 48'd0);
        end else begin
          logic [23:0] el, er;
          string tg;
          el = q_l.pop_front(); er = q_r.pop_front(); tg = q_tag.pop_front();
          check(out_left == el && out_right == er, tg, {out_left, out_right}, {el, er});
        end
        last_l = out_left; last_r = out_right;
      end else begin
        check(out_left == last_l && out_right == last_r, "R9 hold",
              {out_left, out_right}, {last_l, last_r});
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_left == 0 && out_right == 0, "R1 in reset",
          {out_left, out_right}, 48'd0);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check(out_valid == 0 && out_left == 0 && out_right == 0, "R1 after reset",
          {out_left, out_right}, 48'd0);
  endtask

  task automatic ramp(input int n, input int base);
    for (int i = 0; i < n; i++)
      send(24'(base + i), 24'(24'h400000 + base + i));
  endtask

  initial begin
    model_reset();
    do_reset();

    // R3/R4: minimum setting, silent start then 65-frame delay
    dly_sel = 6'h00;
    ramp(200, 24'h000100);

    // R5: bit 5 alone -> 129
    dly_sel = 6'b100000;
    ramp(300, 24'h010000);

    // R2: bit 0 alone carries 2048 -> 2113
    dly_sel = 6'b000001;
    ramp(2200, 24'h020000);

    // R6: change inside a running mute (1089 then 193)
    dly_sel = 6'b000010;
    ramp(500, 24'h030000);
    dly_sel = 6'b010000;
    ramp(400, 24'h040000);

    // R8: bypass on the strobe that starts a mute, then normal
    dly_sel = 6'b000100;
    bypass = 1'b1;
    ramp(50, 24'h050000);
    bypass = 1'b0;
    ramp(600, 24'h060000);
    bypass = 1'b1;
    ramp(20, 24'h070000);
    bypass = 1'b0;
    ramp(100, 24'h080000);

    // R3/R7: maximum setting with non-audio words
    dly_sel = 6'h3F;
    na_phase = 1;
    for (int i = 0; i < 4300; i++) begin
      logic [23:0] a, b;
      case (i % 5)
        0: begin a = 24'hFFFFFF; b = 24'h000000; end
        1: begin a = 24'h800000; b = 24'h000001; end
        2: begin a = 24'hA5A5A5; b = 24'h5A5A5A; end
        default: begin a = 24'($urandom); b = 24'($urandom); end
      endcase
      send(a, b);
    end
    na_phase = 0;

    // R1/R4: reset mid-stream
    repeat (3) @(negedge clk);
    do_reset();
    dly_sel = 6'h00;
    ramp(100, 24'h090000);

    repeat (4) @(negedge clk);
    check(q_l.size() == 0, "R9 all outputs seen", 48'(q_l.size()), 48'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule